// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Register Bank

This block is the register file and pad-side logic of a 16-pin general-purpose I/O port. It sits on a simple 32-bit bus made of a write strobe, a read strobe, a byte address and a data word. Software controls two registers: the output level of each pin and whether each pin is driven. Each of these registers has a write-only alias that sets the bits written as one, and another that clears them. Software can therefore change single pins without a read-modify-write sequence.

Each pin has a configuration word with two fields. The open-drain bit turns a high output into "not driven". The alternate-source bit takes the pin's output value from a one-bit modulator input instead of the output register. A read-only input register shows the pad level for pins that are inputs, after a two-flop synchronizer. For pins that are driven, it shows the value being driven.

Reads are registered. Read data appears one cycle after the read strobe and is zero in every other cycle.

Top module: `gpio_bank`

## Requirements
- R1: A synchronous active-low reset clears the output register, the enable register and every configuration word. After reset every pin has pad_oe low and every register reads zero.
- R2: Byte offset 0x00 is the output-level register. A write stores wdata[15:0] (bits 31:16 are dropped), and a read returns the stored value zero-extended.
- R3: A write to offset 0x04 ORs wdata into the output-level register, and a write to 0x08 clears the bits written as one. Bits written as zero keep their value. Both aliases read as zero.
- R4: Offsets 0x0C, 0x10 and 0x14 are the enable register, its set alias and its clear alias, with the same semantics as R2 and R3. A push-pull pin drives pad_oe equal to its enable bit and pad_out equal to its output value.
- R5: Offset 0x18 is the input register. For an enabled pin, its bit is the value the pin drives. For a pin that is not enabled, its bit is pad_in delayed by two clock edges. Writes to 0x18 change nothing.
- R6: The configuration word of pin i is at 0x28 + 4*i for i = 0..15. Only bit 0 (alternate source) and bit 2 (open drain) are stored, and the other bits read as zero.
- R7: When bit 2 of a pin's configuration word is set, pad_out is 0. pad_oe is high only when the pin is enabled and its output value is 0, so the pin never drives high.
- R8: When bit 0 of a pin's configuration word is set, the pin's output value is alt_src instead of its output-register bit. This applies to both drive modes and to the input register.
- R9: rdata carries the read data in the cycle after rd_en and is zero otherwise. A read and a write to the same register in one cycle return the value from before the write.
- R10: Addresses 0x1C to 0x27 and 0x68 upward read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Byte address (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| alt_src | input | 1 | Alternate modulator output value |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |

## Verification
Two things can meet in one clock edge: a register update from a write, and the capture of read data from the same register. The bench raises wr_en and rd_en together on the output-level offset with a new value. It expects rdata to carry the old value, and a follow-up read to return the new one. A second race is a pad input change while a read of the input register is already under way. The bench changes pad_in, reads at once and expects the old level, then waits two edges and expects the new level.

// File: rtl/gpio_pkg.sv
// gpio_pkg: word indices of the register map and configuration bit positions
// shared by the register file, the checker and the top.
// Assumes byte addresses with the two low bits ignored.
package gpio_pkg;
    localparam int unsigned IDX_OUT     = 0;   // output level
    localparam int unsigned IDX_OUT_SET = 1;
    localparam int unsigned IDX_OUT_CLR = 2;
    localparam int unsigned IDX_EN      = 3;   // output enable
    localparam int unsigned IDX_EN_SET  = 4;
    localparam int unsigned IDX_EN_CLR  = 5;
    localparam int unsigned IDX_IN      = 6;   // read-only input
    localparam int unsigned IDX_CFG0    = 10;  // first per-pin config word
    localparam int unsigned CFG_ALT_BIT = 0;
    localparam int unsigned CFG_OD_BIT  = 2;
endpackage

// File: rtl/gpio_in_sync.sv
// gpio_in_sync: two-flop synchronizer per bit for the asynchronous pad inputs.
// Assumes pad_in may change at any time; output lags by two rising edges.
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the pad level through two flops, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pin_drv.sv
// gpio_pin_drv: pad-side logic of one pin. Picks the output source, applies
// open-drain conversion and forms the value seen by the input register.
// Purely combinational; assumes the synchronized pad level is supplied.
module gpio_pin_drv (
    input  logic out_bit,
    input  logic en_bit,
    input  logic alt_sel,
    input  logic od_sel,
    input  logic alt_src,
    input  logic sync_bit,
    output logic pad_out,
    output logic pad_oe,
    output logic in_bit
);
    logic drv_val;

    // Choose the source value, then shape it into pad level and enable.
    always_comb begin
        drv_val = alt_sel ? alt_src : out_bit;
        pad_out = od_sel ? 1'b0 : drv_val;
        pad_oe  = en_bit & (od_sel ? ~drv_val : 1'b1);
        in_bit  = en_bit ? drv_val : sync_bit;
    end
endmodule

// File: rtl/gpio_regfile.sv
// gpio_regfile: bus decode, output/enable registers with set and clear
// aliases, per-pin configuration bits and the registered read mux.
// Assumes one access per strobe; address bits [1:0] are ignored.
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int ADDR_W = 7,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [PINS-1:0]   in_val,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   en_q,
    output logic [PINS-1:0]   alt_q,
    output logic [PINS-1:0]   od_q,
    output logic [DW-1:0]     rdata
);
    localparam int PAD_W = DW - PINS;
    localparam int CFG_PAD = DW - 3;

    int unsigned widx;
    logic [PINS-1:0] wbits;
    logic [PINS-1:0] out_d, en_d;
    logic [DW-1:0]   rd_mux;

    // Word index and the pin-wide slice of the write data.
    always_comb begin
        widx  = int'(addr[ADDR_W-1:2]);
        wbits = wdata[PINS-1:0];
    end

    // Next value of the output and enable registers under plain/set/clear writes.
    always_comb begin
        out_d = out_q;
        en_d  = en_q;
        if (wr_en) begin
            case (widx)
                IDX_OUT:     out_d = wbits;
                IDX_OUT_SET: out_d = out_q | wbits;
                IDX_OUT_CLR: out_d = out_q & ~wbits;
                IDX_EN:      en_d  = wbits;
                IDX_EN_SET:  en_d  = en_q | wbits;
                IDX_EN_CLR:  en_d  = en_q & ~wbits;
                default: ;
            endcase
        end
    end

    // Hold output and enable state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            en_q  <= '0;
        end else begin
            out_q <= out_d;
            en_q  <= en_d;
        end
    end

    // Store the two implemented bits of each configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_q <= '0;
            od_q  <= '0;
        end else begin
            for (int p = 0; p < PINS; p++) begin
                if (wr_en && widx == IDX_CFG0 + p) begin
                    alt_q[p] <= wdata[CFG_ALT_BIT];
                    od_q[p]  <= wdata[CFG_OD_BIT];
                end
            end
        end
    end

    // Read mux: aliases, reserved and unmapped words return zero.
    always_comb begin
        rd_mux = '0;
        case (widx)
            IDX_OUT: rd_mux = {{PAD_W{1'b0}}, out_q};
            IDX_EN:  rd_mux = {{PAD_W{1'b0}}, en_q};
            IDX_IN:  rd_mux = {{PAD_W{1'b0}}, in_val};
            default: ;
        endcase
        for (int p = 0; p < PINS; p++) begin
            if (widx == IDX_CFG0 + p)
                rd_mux = {{CFG_PAD{1'b0}}, od_q[p], 1'b0, alt_q[p]};
        end
    end

    // Register read data; zero in cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? rd_mux : '0;
    end
endmodule

// File: rtl/gpio_bank.sv
// gpio_bank: top of the GPIO port. Joins the register file, the input
// synchronizer and one pad driver per pin.
// Assumes a single clock domain for the bus; pad_in is asynchronous.
module gpio_bank #(
    parameter int PINS   = 16,
    parameter int ADDR_W = 7,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              alt_src,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    logic [PINS-1:0] out_q, en_q, alt_q, od_q, sync_q, in_val;

    gpio_regfile #(.PINS(PINS), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .in_val (in_val),
        .out_q  (out_q),
        .en_q   (en_q),
        .alt_q  (alt_q),
        .od_q   (od_q),
        .rdata  (rdata)
    );

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_pin_drv u_drv (
            .out_bit  (out_q[i]),
            .en_bit   (en_q[i]),
            .alt_sel  (alt_q[i]),
            .od_sel   (od_q[i]),
            .alt_src  (alt_src),
            .sync_bit (sync_q[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i]),
            .in_bit   (in_val[i])
        );
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// gpio_bank_chk: protocol checker bound into gpio_bank. Watches ports and
// the stored register state; drives nothing.
module gpio_bank_chk
    import gpio_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int ADDR_W = 7,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     rdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   out_q,
    input logic [PINS-1:0]   en_q,
    input logic [PINS-1:0]   od_q
);
    logic set_wr, unmapped_wr;

    // Decode the accesses the properties depend on.
    always_comb begin
        set_wr      = wr_en && int'(addr[ADDR_W-1:2]) == IDX_OUT_SET;
        unmapped_wr = wr_en && int'(addr[ADDR_W-1:2]) >= IDX_CFG0 + PINS;
    end

    assert_oe_clear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0));

    assert_set_alias_ors_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> (out_q == ($past(out_q) | $past(wdata[PINS-1:0]))));

    assert_oe_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~en_q) == '0);

    assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & od_q) == '0);

    assert_idle_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    assert_unmapped_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_wr |=> ($stable(out_q) && $stable(en_q) && $stable(od_q)));
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .out_q   (out_q),
    .en_q    (en_q),
    .od_q    (od_q)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        alt_src = 1'b0;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;

    int checks = 0, fails = 0;
    logic [15:0] m_out = '0, m_en = '0, m_alt = '0, m_od = '0;

    always #2 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .alt_src(alt_src), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [6:0]  a;
        logic [31:0] d;   // write data, or expected read data
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 7'h00, 32'h0000A5A5},  // R2 plain write
        '{1'b0, 7'h00, 32'h0000A5A5},  // R2
        '{1'b1, 7'h04, 32'h00000F0F},  // R3 set alias
        '{1'b0, 7'h00, 32'h0000AFAF},  // R3
        '{1'b0, 7'h04, 32'h00000000},  // R3 alias reads zero
        '{1'b1, 7'h08, 32'h0000A000},  // R3 clear alias
        '{1'b0, 7'h00, 32'h00000FAF},  // R3
        '{1'b0, 7'h08, 32'h00000000},  // R3
        '{1'b1, 7'h00, 32'hFFFF1234},  // R2 upper half dropped
        '{1'b0, 7'h00, 32'h00001234},  // R2
        '{1'b1, 7'h0C, 32'h000000FF},  // R4
        '{1'b1, 7'h10, 32'h00000F00},  // R4 set
        '{1'b1, 7'h14, 32'h0000000F},  // R4 clear
        '{1'b0, 7'h0C, 32'h00000FF0},  // R4
        '{1'b0, 7'h10, 32'h00000000},  // R4
        '{1'b0, 7'h14, 32'h00000000},  // R4
        '{1'b1, 7'h2C, 32'hFFFFFFFF},  // R6 pin 1
        '{1'b0, 7'h2C, 32'h00000005},  // R6
        '{1'b0, 7'h28, 32'h00000000},  // R6 pin 0 untouched
        '{1'b1, 7'h64, 32'h00000004},  // R6 pin 15
        '{1'b0, 7'h64, 32'h00000004},  // R6
        '{1'b1, 7'h74, 32'h0000FFFF},  // R10 unmapped
        '{1'b0, 7'h74, 32'h00000000},  // R10
        '{1'b1, 7'h18, 32'h0000FFFF},  // R5 write to input ignored
        '{1'b0, 7'h00, 32'h00001234},  // R10 / R5 no side effect
        '{1'b0, 7'h0C, 32'h00000FF0},  // R10 / R5
        '{1'b0, 7'h20, 32'h00000000}   // R10 reserved word
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model of a bus write, written from the requirements.
    task automatic model_write(input logic [6:0] a, input logic [31:0] d);
        int w = int'(a[6:2]);
        case (w)
            0: m_out = d[15:0];
            1: m_out = m_out | d[15:0];
            2: m_out = m_out & ~d[15:0];
            3: m_en  = d[15:0];
            4: m_en  = m_en | d[15:0];
            5: m_en  = m_en & ~d[15:0];
            default: if (w >= 10 && w < 26) begin
                m_alt[w-10] = d[0];
                m_od[w-10]  = d[2];
            end
        endcase
    endtask

    function automatic logic [15:0] drv_val();
        return (m_alt & {16{alt_src}}) | (~m_alt & m_out);
    endfunction

    task automatic do_write(input logic [6:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [6:0] a, output logic [31:0] r);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        r = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #400000;
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [15:0] exp_in;
        idle(3);
        chk("R1 pad_oe in reset", {16'h0, pad_oe}, 32'h0);
        rst_n = 1'b1;
        idle(1);
        do_read(7'h00, r); chk("R1 out after reset", r, 32'h0);
        do_read(7'h3C, r); chk("R1 cfg after reset", r, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) do_write(VEC[i].a, VEC[i].d);
            else begin
                do_read(VEC[i].a, r);
                chk($sformatf("vector %0d (R2/R3/R4/R6/R10)", i), r, VEC[i].d);
            end
        end

        // R4 push-pull drive: pins 4..11 enabled, out 0x1234
        chk("R4 pad_oe", {16'h0, pad_oe}, 32'h00000FF0);
        chk("R4 pad_out", {16'h0, pad_out & 16'h0FF0}, 32'h00000230);

        // R7 open drain on pin 4 (drives 1) and pin 8 (drives 0)
        do_write(7'h38, 32'h4);
        do_write(7'h48, 32'h4);
        chk("R7 od pad_oe", {16'h0, pad_oe}, 32'h00000FE0);
        chk("R7 od pad_out", {16'h0, pad_out & 16'h0FF0}, 32'h00000220);

        // R8 alternate source on pin 6
        do_write(7'h40, 32'h1);
        alt_src = 1'b1; idle(1);
        chk("R8 alt high", {16'h0, pad_out & 16'h0FF0}, 32'h00000260);
        alt_src = 1'b0; idle(1);
        chk("R8 alt low", {16'h0, pad_out & 16'h0FF0}, 32'h00000220);

        // R8 with R7: pin 7 alternate + open drain
        do_write(7'h44, 32'h5);
        alt_src = 1'b1; idle(1);
        chk("R8 alt od high", {16'h0, pad_oe}, 32'h00000F60);
        alt_src = 1'b0; idle(1);
        chk("R8 alt od low", {16'h0, pad_oe}, 32'h00000FE0);

        // R5 input register: inputs synchronized, driven pins show drive value
        pad_in = 16'hA55A; alt_src = 1'b1; idle(2);
        exp_in = (pad_in & ~m_en) | (drv_val() & m_en);
        do_read(7'h18, r); chk("R5 input mix", r, {16'h0, exp_in});
        alt_src = 1'b0;
        exp_in = (pad_in & ~m_en) | (drv_val() & m_en);
        pad_in = 16'h5AA5;
        do_read(7'h18, r); chk("R5 old level before sync", r, {16'h0, exp_in});
        idle(2);
        exp_in = (pad_in & ~m_en) | (drv_val() & m_en);
        do_read(7'h18, r); chk("R5 new level after sync", r, {16'h0, exp_in});

        // R9 read and write to the same word in one cycle
        wr_en = 1'b1; rd_en = 1'b1; addr = 7'h00; wdata = 32'h00007777;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 same-cycle read old", rdata, {16'h0, m_out});
        model_write(7'h00, 32'h00007777);
        idle(1);
        chk("R9 idle rdata zero", rdata, 32'h0);
        do_read(7'h00, r); chk("R9 new value visible", r, 32'h00007777);

        // R1 reset in mid-run
        rst_n = 1'b0; idle(2);
        chk("R1 pad_oe mid reset", {16'h0, pad_oe}, 32'h0);
        rst_n = 1'b1; idle(1);
        do_read(7'h00, r); chk("R1 out cleared", r, 32'h0);
        do_read(7'h0C, r); chk("R1 enable cleared", r, 32'h0);
        do_read(7'h38, r); chk("R1 cfg cleared", r, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule